// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This block decides, for the instruction in the execute stage of a five-stage load/store pipeline, where each ALU operand should come from. It has three choices: the value read from the register file, the result that the instruction one ahead (now in the memory stage) is about to write, or the value that the instruction two ahead (now in write-back) is writing. The block compares the two source register numbers of the executing instruction against the destination numbers held in the two later pipeline registers. Each match counts only if that stage's register-write enable is set.

When both later stages hold the needed register, the younger one (the memory stage) wins. A chain of accumulating instructions therefore always sees the most recent value. Register zero is hardwired and is never bypassed. With these rules, dependent back-to-back ALU instructions issue every cycle without a stall.

A second path handles a load followed at once by a store of the loaded register. If the load sits in write-back and the store sits in the memory stage, the store data is taken from the write-back value instead of the stale copy the store carried down the pipe.

The top module contains the operand and store-data multiplexers as well as the select logic, so it can be tested on its own. It is purely combinational.

Top module: `fwd_unit`

## Requirements
- R1: `fwdA` is 2'b10 whenever `memRegWrite` is 1, `memRd` is nonzero and `memRd` equals `exRs`.
- R2: `fwdA` is 2'b01 when R1 does not apply and `wbRegWrite` is 1, `wbRd` is nonzero and `wbRd` equals `exRs`. In every other case `fwdA` is 2'b00.
- R3: `fwdB` follows the rules of R1 and R2 applied to `exRt` instead of `exRs`, and depends on neither `exRs` nor `fwdA`.
- R4: A destination of register 0 is never bypassed. A source of register 0 always gets select 2'b00, whatever the write enables and destinations are.
- R5: The select code 2'b11 never appears on `fwdA` or `fwdB`.
- R6: `aluOpA` is `rfA` for select 2'b00, `memAluResult` for 2'b10 and `wbData` for 2'b01. `aluOpB` does the same with `rfB` under `fwdB`.
- R7: `storeSel` is 1 exactly when `memIsStore`, `wbIsLoad` and `wbRegWrite` are all 1, `wbRd` is nonzero and `wbRd` equals `memRt`.
- R8: `memWriteData` is `wbData` when `storeSel` is 1 and `memStoreData` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exRs | input | REG_W | First source register of the execute-stage instruction |
| exRt | input | REG_W | Second source register of the execute-stage instruction |
| memRd | input | REG_W | Destination register held in the memory-stage pipeline register |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| memRt | input | REG_W | Store-data register of the memory-stage instruction |
| memIsStore | input | 1 | Memory-stage instruction is a store |
| wbRd | input | REG_W | Destination register held in the write-back pipeline register |
| wbRegWrite | input | 1 | Write-back instruction writes a register |
| wbIsLoad | input | 1 | Write-back instruction is a load |
| rfA | input | DATA_W | Register-file value for the first operand |
| rfB | input | DATA_W | Register-file value for the second operand |
| memAluResult | input | DATA_W | Result held in the memory-stage pipeline register |
| wbData | input | DATA_W | Value being written back (ALU result or loaded data) |
| memStoreData | input | DATA_W | Store data carried by the memory-stage instruction |
| fwdA | output | 2 | Select for the first ALU operand |
| fwdB | output | 2 | Select for the second ALU operand |
| storeSel | output | 1 | Store data taken from write-back |
| aluOpA | output | DATA_W | First ALU operand |
| aluOpB | output | DATA_W | Second ALU operand |
| memWriteData | output | DATA_W | Data presented to the data memory |

## Verification
The hardest cases are the overlaps: both later stages naming the same register, with either or both write enables cleared. Register zero showing up as a source and as a destination at the same time is another. Reaching all of these by chance with wide register numbers is rare. The bench therefore builds the unit with two-bit register numbers and walks every combination of all five register fields and all four flags, which forces every coincidence. For each vector it compares all six outputs against values worked out from the priority rules.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwdSel_e;

  typedef struct packed {
    fwdSel_e selA;
    fwdSel_e selB;
    logic    storeSel;
  } fwdCtl_t;

endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic [REG_W-1:0] memRd,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] memRt,
  input  logic             memIsStore,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbRegWrite,
  input  logic             wbIsLoad,
  output fwdCtl_t          ctl
);
  localparam int NUM_OPS = 2;
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [REG_W-1:0] srcReg [NUM_OPS];
  fwdSel_e          opSel  [NUM_OPS];

  // a destination only counts if its stage writes and it is not register zero
  logic memLive, wbLive;
  assign memLive = memRegWrite && (memRd != ZERO_REG);
  assign wbLive  = wbRegWrite  && (wbRd  != ZERO_REG);

  assign srcReg[0] = exRs;
  assign srcReg[1] = exRt;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    logic memHit, wbHit;
    assign memHit = memLive && (memRd == srcReg[g]);
    assign wbHit  = wbLive  && (wbRd  == srcReg[g]);
    always_comb begin
      if (memHit)     opSel[g] = SEL_MEM;
      else if (wbHit) opSel[g] = SEL_WB;
      else            opSel[g] = SEL_RF;
    end
  end

  logic storeHit;
  assign storeHit = memIsStore && wbIsLoad && wbLive && (wbRd == memRt);

  assign ctl.selA     = opSel[0];
  assign ctl.selB     = opSel[1];
  assign ctl.storeSel = storeHit;

  always_comb begin
    if (!$isunknown({exRs, exRt, memRd, wbRd, memRt, memRegWrite, wbRegWrite,
                     memIsStore, wbIsLoad})) begin
      // R5
      no_code11_chk: assert (ctl.selA != 2'b11 && ctl.selB != 2'b11)
        else $error("select code 11 generated");
      // R4
      zero_src_chk: assert ((exRs != ZERO_REG || ctl.selA == SEL_RF) &&
                            (exRt != ZERO_REG || ctl.selB == SEL_RF))
        else $error("register zero bypassed");
      // R1
      mem_prio_chk: assert (!(memRegWrite && memRd == exRs && exRs != ZERO_REG) ||
                            ctl.selA == SEL_MEM)
        else $error("memory-stage match did not win");
      // R7
      store_match_chk: assert (!ctl.storeSel ||
                               (wbRd == memRt && memIsStore && wbIsLoad))
        else $error("store bypass without matching load");
    end
  end

endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdCtl_t           ctl,
  input  logic [DATA_W-1:0] rfA,
  input  logic [DATA_W-1:0] rfB,
  input  logic [DATA_W-1:0] memAluResult,
  input  logic [DATA_W-1:0] wbData,
  input  logic [DATA_W-1:0] memStoreData,
  output logic [DATA_W-1:0] aluOpA,
  output logic [DATA_W-1:0] aluOpB,
  output logic [DATA_W-1:0] memWriteData
);

  function automatic logic [DATA_W-1:0] pick(fwdSel_e sel, logic [DATA_W-1:0] rf,
                                             logic [DATA_W-1:0] memV,
                                             logic [DATA_W-1:0] wbV);
    case (sel)
      SEL_MEM: return memV;
      SEL_WB:  return wbV;
      default: return rf;
    endcase
  endfunction

  assign aluOpA       = pick(ctl.selA, rfA, memAluResult, wbData);
  assign aluOpB       = pick(ctl.selB, rfB, memAluResult, wbData);
  assign memWriteData = ctl.storeSel ? wbData : memStoreData;

  always_comb begin
    if (!$isunknown({ctl, rfA, rfB, memAluResult, wbData, memStoreData})) begin
      // R6
      opa_mux_chk: assert (ctl.selA != SEL_WB || aluOpA == wbData)
        else $error("operand A not taken from write-back");
      // R8
      store_mux_chk: assert (ctl.storeSel || memWriteData == memStoreData)
        else $error("store data altered without bypass");
    end
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  exRs,
  input  logic [REG_W-1:0]  exRt,
  input  logic [REG_W-1:0]  memRd,
  input  logic              memRegWrite,
  input  logic [REG_W-1:0]  memRt,
  input  logic              memIsStore,
  input  logic [REG_W-1:0]  wbRd,
  input  logic              wbRegWrite,
  input  logic              wbIsLoad,
  input  logic [DATA_W-1:0] rfA,
  input  logic [DATA_W-1:0] rfB,
  input  logic [DATA_W-1:0] memAluResult,
  input  logic [DATA_W-1:0] wbData,
  input  logic [DATA_W-1:0] memStoreData,
  output logic [1:0]        fwdA,
  output logic [1:0]        fwdB,
  output logic              storeSel,
  output logic [DATA_W-1:0] aluOpA,
  output logic [DATA_W-1:0] aluOpB,
  output logic [DATA_W-1:0] memWriteData
);
  fwdCtl_t ctl;

  fwd_ctrl #(.REG_W(REG_W)) i_ctrl (
    .exRs(exRs), .exRt(exRt), .memRd(memRd), .memRegWrite(memRegWrite),
    .memRt(memRt), .memIsStore(memIsStore), .wbRd(wbRd),
    .wbRegWrite(wbRegWrite), .wbIsLoad(wbIsLoad), .ctl(ctl)
  );

  fwd_datapath #(.DATA_W(DATA_W)) i_dp (
    .ctl(ctl), .rfA(rfA), .rfB(rfB), .memAluResult(memAluResult),
    .wbData(wbData), .memStoreData(memStoreData),
    .aluOpA(aluOpA), .aluOpB(aluOpB), .memWriteData(memWriteData)
  );

  assign fwdA     = ctl.selA;
  assign fwdB     = ctl.selB;
  assign storeSel = ctl.storeSel;

endmodule

// File: tb/test_fwd_unit.sv
module test_fwd_unit;
  localparam int RW = 2;
  localparam int DW = 32;
  localparam logic [DW-1:0] V_RFA = 32'hA0A0_0001;
  localparam logic [DW-1:0] V_RFB = 32'hB0B0_0002;
  localparam logic [DW-1:0] V_MEM = 32'hC0C0_0003;
  localparam logic [DW-1:0] V_WB  = 32'hD0D0_0004;
  localparam logic [DW-1:0] V_ST  = 32'hE0E0_0005;

  logic clk = 0;
  always #2 clk = ~clk;

  logic [RW-1:0] exRs, exRt, memRd, memRt, wbRd;
  logic memRegWrite, memIsStore, wbRegWrite, wbIsLoad;
  logic [1:0] fwdA, fwdB;
  logic storeSel;
  logic [DW-1:0] aluOpA, aluOpB, memWriteData;

  int tests = 0, fails = 0;
  bit finished = 0;

  fwd_unit #(.REG_W(RW), .DATA_W(DW)) i_fwd_unit (
    .exRs(exRs), .exRt(exRt), .memRd(memRd), .memRegWrite(memRegWrite),
    .memRt(memRt), .memIsStore(memIsStore), .wbRd(wbRd),
    .wbRegWrite(wbRegWrite), .wbIsLoad(wbIsLoad),
    .rfA(V_RFA), .rfB(V_RFB), .memAluResult(V_MEM), .wbData(V_WB),
    .memStoreData(V_ST), .fwdA(fwdA), .fwdB(fwdB), .storeSel(storeSel),
    .aluOpA(aluOpA), .aluOpB(aluOpB), .memWriteData(memWriteData)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (rs=%0d rt=%0d mRd=%0d mWe=%0b wRd=%0d wWe=%0b)",
               req, act, exp, exRs, exRt, memRd, memRegWrite, wbRd, wbRegWrite);
    end
  endtask

  // expected select from the priority rules (R1, R2, R4)
  function automatic logic [1:0] expSel(logic [RW-1:0] src);
    if (memRegWrite && memRd != 0 && memRd == src) return 2'b10;
    if (wbRegWrite && wbRd != 0 && wbRd == src)   return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] expOp(logic [1:0] sel, logic [DW-1:0] rf);
    return (sel == 2'b10) ? V_MEM : (sel == 2'b01) ? V_WB : rf;
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    // idle state: nothing writes, all selects from register file
    {exRs, exRt, memRd, memRt, wbRd} = '0;
    {memRegWrite, memIsStore, wbRegWrite, wbIsLoad} = '0;
    @(negedge clk); #1;
    check("R2 idle fwdA", DW'(fwdA), DW'(2'b00));
    check("R3 idle fwdB", DW'(fwdB), DW'(2'b00));
    check("R7 idle storeSel", DW'(storeSel), DW'(1'b0));
    check("R8 idle store data", memWriteData, V_ST);

    // register-zero destination with write enables set (R4)
    memRd = 0; wbRd = 0; memRegWrite = 1; wbRegWrite = 1;
    @(negedge clk); #1;
    check("R4 zero dest A", DW'(fwdA), DW'(2'b00));
    check("R4 zero dest opA", aluOpA, V_RFA);

    // exhaustive sweep
    for (int v = 0; v < (1 << 14); v++) begin
      @(negedge clk);
      {exRs, exRt, memRd, memRt, wbRd, memRegWrite, memIsStore, wbRegWrite, wbIsLoad} = v[13:0];
      #1;
      begin
        logic [1:0] eA, eB;
        logic eS;
        eA = expSel(exRs);
        eB = expSel(exRt);
        eS = memIsStore && wbIsLoad && wbRegWrite && wbRd != 0 && wbRd == memRt;
        if (eA == 2'b10) check("R1 fwdA", DW'(fwdA), DW'(eA));
        else             check("R2 fwdA", DW'(fwdA), DW'(eA));
        check("R3 fwdB", DW'(fwdB), DW'(eB));
        if (exRs == 0) check("R4 zero src", DW'(fwdA), DW'(2'b00));
        check("R5 no code 11", DW'(fwdA == 2'b11 || fwdB == 2'b11), DW'(1'b0));
        check("R6 aluOpA", aluOpA, expOp(eA, V_RFA));
        check("R6 aluOpB", aluOpB, expOp(eB, V_RFB));
        check("R7 storeSel", DW'(storeSel), DW'(eS));
        check("R8 memWriteData", memWriteData, eS ? V_WB : V_ST);
      end
    end
    finished = 1;
    finish_run();
  end

endmodule